// File: doc/BRIEF.md
# Bridging Fault Injection Wrapper

This wrapper sits between two source nets and their two destination nets. It lets faulty circuit behaviour be reproduced in hardware. A 4-bit mode code is held for each net pair. The code selects one of three things: clean pass-through, one of eight models of a short between the two nets, or a stuck-at value on either net. The parameter `N` sets the number of independent pairs. Each pair reads its own field of the mode bus.

The path from the sources to the destinations is purely combinational. With the default `REG_MODE` setting, the mode codes are captured into a register only when the load strobe is high at a rising clock edge. The fault set therefore changes only between test patterns. With `REG_MODE` cleared, the mode bus drives the selection directly. A control module decodes each pair's code into a small one-hot strobe struct. A datapath module uses that struct to select each destination value.

Top module: `bridge_fault_wrap`

## Requirements
- R1: While reset is low, and after it is released until the first load, every pair is in mode 0, whatever the mode bus or load strobe carry. Mode 0 means each destination equals its own source.
- R2: Mode 0 and the spare codes 13, 14 and 15 give clean pass-through: dstA equals srcA and dstB equals srcB.
- R3: Wired-short modes. Code 1 drives both destinations with srcA AND srcB. Code 2 drives both with srcA OR srcB.
- R4: Code 3 (net A overpowers net B) drives both destinations with srcA. Code 4 (net B overpowers net A) drives both with srcB.
- R5: With code 5, dstA equals srcA and dstB equals srcA AND srcB. Code 6 is the same except that dstB equals srcA OR srcB.
- R6: With code 7, dstB equals srcB and dstA equals srcA AND srcB. Code 8 is the same except that dstA equals srcA OR srcB.
- R7: Code 9 forces dstA to 0 and code 10 forces dstA to 1. In both, dstB equals srcB.
- R8: Code 11 forces dstB to 0 and code 12 forces dstB to 1. In both, dstA equals srcA.
- R9: The active mode of every pair changes only at a rising clock edge with modeLoad high. It then takes the value modeIn had at that edge. A change on modeIn with modeLoad low has no effect on the outputs.
- R10: Pair i takes its code from modeIn bits [4i+3:4i], and its sources and destinations are bit i of each bus. Pairs do not affect one another.
- R11: The destinations follow source changes within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rstN | input | 1 | Asynchronous active-low reset; clears all modes to 0 |
| modeLoad | input | 1 | Strobe that captures modeIn at a rising edge |
| modeIn | input | 4*N | Mode code of each pair; pair i uses bits [4i+3:4i] |
| srcA | input | N | Source net A of each pair |
| srcB | input | N | Source net B of each pair |
| dstA | output | N | Destination net A of each pair |
| dstB | output | N | Destination net B of each pair |

## Verification
Two functions can fall in the same cycle: a source change and a mode load. The bench drives new source values and a new mode with the load strobe together, just after a falling edge. Before the next rising edge, the destinations must show the new sources under the old mode. Just after that edge, they must show the same sources under the new mode. A table walk sweeps all 16 codes over all four source combinations. In that walk, every pair gets a different pattern, so a mix-up between pairs shows as a mismatch.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE   = 4'd0,
    MODE_WAND   = 4'd1,
    MODE_WOR    = 4'd2,
    MODE_A_DOM  = 4'd3,
    MODE_B_DOM  = 4'd4,
    MODE_A_DAND = 4'd5,
    MODE_A_DOR  = 4'd6,
    MODE_B_DAND = 4'd7,
    MODE_B_DOR  = 4'd8,
    MODE_A_SA0  = 4'd9,
    MODE_A_SA1  = 4'd10,
    MODE_B_SA0  = 4'd11,
    MODE_B_SA1  = 4'd12
  } bridgeMode_e;

  // One-hot choice of the value one destination takes
  typedef struct packed {
    logic one;
    logic zero;
    logic orv;
    logic andv;
    logic other;
    logic own;
  } pick_t;

  // Strobes from control to datapath for one pair
  typedef struct packed {
    pick_t dstA;
    pick_t dstB;
  } bridgeSel_t;

  localparam pick_t P_OWN   = '{one: 1'b0, zero: 1'b0, orv: 1'b0, andv: 1'b0, other: 1'b0, own: 1'b1};
  localparam pick_t P_OTHER = '{one: 1'b0, zero: 1'b0, orv: 1'b0, andv: 1'b0, other: 1'b1, own: 1'b0};
  localparam pick_t P_AND   = '{one: 1'b0, zero: 1'b0, orv: 1'b0, andv: 1'b1, other: 1'b0, own: 1'b0};
  localparam pick_t P_OR    = '{one: 1'b0, zero: 1'b0, orv: 1'b1, andv: 1'b0, other: 1'b0, own: 1'b0};
  localparam pick_t P_ZERO  = '{one: 1'b0, zero: 1'b1, orv: 1'b0, andv: 1'b0, other: 1'b0, own: 1'b0};
  localparam pick_t P_ONE   = '{one: 1'b1, zero: 1'b0, orv: 1'b0, andv: 1'b0, other: 1'b0, own: 1'b0};

  function automatic bridgeSel_t decodeMode(input logic [MODE_W-1:0] code);
    bridgeSel_t s;
    s.dstA = P_OWN;
    s.dstB = P_OWN;
    case (code)
      MODE_WAND:   begin s.dstA = P_AND;   s.dstB = P_AND;   end
      MODE_WOR:    begin s.dstA = P_OR;    s.dstB = P_OR;    end
      MODE_A_DOM:  begin s.dstA = P_OWN;   s.dstB = P_OTHER; end
      MODE_B_DOM:  begin s.dstA = P_OTHER; s.dstB = P_OWN;   end
      MODE_A_DAND: begin s.dstA = P_OWN;   s.dstB = P_AND;   end
      MODE_A_DOR:  begin s.dstA = P_OWN;   s.dstB = P_OR;    end
      MODE_B_DAND: begin s.dstA = P_AND;   s.dstB = P_OWN;   end
      MODE_B_DOR:  begin s.dstA = P_OR;    s.dstB = P_OWN;   end
      MODE_A_SA0:  begin s.dstA = P_ZERO;  s.dstB = P_OWN;   end
      MODE_A_SA1:  begin s.dstA = P_ONE;   s.dstB = P_OWN;   end
      MODE_B_SA0:  begin s.dstA = P_OWN;   s.dstB = P_ZERO;  end
      MODE_B_SA1:  begin s.dstA = P_OWN;   s.dstB = P_ONE;   end
      default:     begin s.dstA = P_OWN;   s.dstB = P_OWN;   end
    endcase
    return s;
  endfunction

  // Value of one destination given its one-hot choice
  function automatic logic resolvePick(input pick_t p, input logic own, input logic other);
    return (p.own   & own)
         | (p.other & other)
         | (p.andv  & (own & other))
         | (p.orv   & (own | other))
         | (p.one);
  endfunction

endpackage

// File: rtl/bridge_fault_ctrl.sv
module bridge_fault_ctrl
  import bfw_pkg::*;
#(
  parameter int N        = 4,
  parameter bit REG_MODE = 1'b1,
  localparam int BUS_W   = N * MODE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeLoad,
  input  logic [BUS_W-1:0]      modeIn,
  output logic [BUS_W-1:0]      modeAct,
  output bridgeSel_t [N-1:0]    sel
);

  generate
    if (REG_MODE) begin : g_reg
      logic [BUS_W-1:0] modeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          modeQ <= '0;
        end else if (modeLoad) begin
          modeQ <= modeIn;
        end
      end
      assign modeAct = modeQ;
    end else begin : g_direct
      assign modeAct = modeIn;
    end
  endgenerate

  generate
    for (genvar i = 0; i < N; i++) begin : g_dec
      always_comb sel[i] = decodeMode(modeAct[i*MODE_W +: MODE_W]);
    end
  endgenerate

endmodule

// File: rtl/bridge_fault_dp.sv
module bridge_fault_dp
  import bfw_pkg::*;
#(
  parameter int N = 4
) (
  input  bridgeSel_t [N-1:0] sel,
  input  logic [N-1:0]       srcA,
  input  logic [N-1:0]       srcB,
  output logic [N-1:0]       dstA,
  output logic [N-1:0]       dstB
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_pair
      always_comb begin
        dstA[i] = resolvePick(sel[i].dstA, srcA[i], srcB[i]);
        dstB[i] = resolvePick(sel[i].dstB, srcB[i], srcA[i]);
      end
    end
  endgenerate

endmodule

// File: rtl/bridge_fault_wrap.sv
module bridge_fault_wrap
  import bfw_pkg::*;
#(
  parameter int N        = 4,
  parameter bit REG_MODE = 1'b1,
  localparam int BUS_W   = N * MODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic [BUS_W-1:0] modeIn,
  input  logic [N-1:0]     srcA,
  input  logic [N-1:0]     srcB,
  output logic [N-1:0]     dstA,
  output logic [N-1:0]     dstB
);

  logic [BUS_W-1:0]   modeAct;
  bridgeSel_t [N-1:0] sel;

  bridge_fault_ctrl #(.N(N), .REG_MODE(REG_MODE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeLoad (modeLoad),
    .modeIn   (modeIn),
    .modeAct  (modeAct),
    .sel      (sel)
  );

  bridge_fault_dp #(.N(N)) u_dp (
    .sel  (sel),
    .srcA (srcA),
    .srcB (srcB),
    .dstA (dstA),
    .dstB (dstB)
  );

endmodule

// File: rtl/bridge_fault_chk.sv
module bridge_fault_chk
  import bfw_pkg::*;
#(
  parameter int N        = 4,
  parameter bit REG_MODE = 1'b1,
  localparam int BUS_W   = N * MODE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeLoad,
  input logic [BUS_W-1:0] modeIn,
  input logic [BUS_W-1:0] modeAct,
  input logic [N-1:0]     srcA,
  input logic [N-1:0]     srcB,
  input logic [N-1:0]     dstA,
  input logic [N-1:0]     dstB
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_pair
      // R2: clean mode passes both nets through
      a_r2_pass: assert property (@(posedge clk) disable iff (!rstN)
        (modeAct[i*MODE_W +: MODE_W] == MODE_FREE) |-> (dstA[i] == srcA[i] && dstB[i] == srcB[i]));
      // R3: wired-AND short
      a_r3_wired_and: assert property (@(posedge clk) disable iff (!rstN)
        (modeAct[i*MODE_W +: MODE_W] == MODE_WAND) |->
          (dstA[i] == (srcA[i] & srcB[i]) && dstB[i] == (srcA[i] & srcB[i])));
      // R4: net A overpowers net B
      a_r4_a_dom: assert property (@(posedge clk) disable iff (!rstN)
        (modeAct[i*MODE_W +: MODE_W] == MODE_A_DOM) |-> (dstA[i] == srcA[i] && dstB[i] == srcA[i]));
      // R6: B-side dominant-OR
      a_r6_b_dor: assert property (@(posedge clk) disable iff (!rstN)
        (modeAct[i*MODE_W +: MODE_W] == MODE_B_DOR) |->
          (dstA[i] == (srcA[i] | srcB[i]) && dstB[i] == srcB[i]));
      // R7: net A stuck at 0
      a_r7_a_sa0: assert property (@(posedge clk) disable iff (!rstN)
        (modeAct[i*MODE_W +: MODE_W] == MODE_A_SA0) |-> (!dstA[i] && dstB[i] == srcB[i]));
      // R8: net B stuck at 1
      a_r8_b_sa1: assert property (@(posedge clk) disable iff (!rstN)
        (modeAct[i*MODE_W +: MODE_W] == MODE_B_SA1) |-> (dstB[i] && dstA[i] == srcA[i]));
    end

    if (REG_MODE) begin : g_reg_chk
      // R1: first cycle after reset release holds the clean mode
      a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rstN) |-> (modeAct == '0));
      // R9: mode is held without the load strobe
      a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
        !modeLoad |=> $stable(modeAct));
      // R9: mode takes the bus value on a load
      a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
        modeLoad |=> (modeAct == $past(modeIn)));
    end
  endgenerate

endmodule

bind bridge_fault_wrap bridge_fault_chk #(.N(N), .REG_MODE(REG_MODE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeLoad (modeLoad),
  .modeIn   (modeIn),
  .modeAct  (modeAct),
  .srcA     (srcA),
  .srcB     (srcB),
  .dstA     (dstA),
  .dstB     (dstB)
);

// File: tb/bridge_fault_wrap_tb.sv
module bridge_fault_wrap_tb;

  localparam int N = 4;
  localparam int BW = 4 * N;

  // Per code: {code, dstA truth, dstB truth}; truth bit index is {a,b}
  localparam logic [11:0] VECS [16] = '{
    12'h0CA, 12'h188, 12'h2EE, 12'h3CC, 12'h4AA, 12'h5C8, 12'h6CE, 12'h78A,
    12'h8EA, 12'h90A, 12'hAFA, 12'hBC0, 12'hCCF, 12'hDCA, 12'hECA, 12'hFCA
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic          modeLoad;
  logic [BW-1:0] modeIn;
  logic [N-1:0]  srcA, srcB, dstA, dstB;
  logic [BW-1:0] curModes;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bridge_fault_wrap #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeIn(modeIn),
    .srcA(srcA), .srcB(srcB), .dstA(dstA), .dstB(dstB)
  );

  function automatic logic expBit(input logic [3:0] code, input logic a, input logic b, input bit sideB);
    logic [11:0] v = VECS[code];
    int p = {30'd0, a, b};
    return sideB ? v[p] : v[4 + p];
  endfunction

  function automatic string reqOf(input logic [3:0] code);
    case (code)
      4'd1, 4'd2:   return "R3";
      4'd3, 4'd4:   return "R4";
      4'd5, 4'd6:   return "R5";
      4'd7, 4'd8:   return "R6";
      4'd9, 4'd10:  return "R7";
      4'd11, 4'd12: return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic checkAll(input string req, input logic [BW-1:0] modes);
    logic [N-1:0] eA, eB;
    for (int i = 0; i < N; i++) begin
      eA[i] = expBit(modes[i*4 +: 4], srcA[i], srcB[i], 1'b0);
      eB[i] = expBit(modes[i*4 +: 4], srcA[i], srcB[i], 1'b1);
    end
    total++;
    if (dstA !== eA || dstB !== eB) begin
      bad++;
      $display("FAIL %s: dstA=%b dstB=%b expected dstA=%b dstB=%b (src A=%b B=%b)",
               req, dstA, dstB, eA, eB, srcA, srcB);
    end
  endtask

  task automatic loadModes(input logic [BW-1:0] m);
    @(negedge clk);
    modeIn   = m;
    modeLoad = 1'b1;
    @(negedge clk);
    modeLoad = 1'b0;
    curModes = m;
  endtask

  initial begin
    rstN     = 1'b0;
    modeLoad = 1'b1;
    modeIn   = {N{4'd1}};
    srcA     = 4'b1010;
    srcB     = 4'b0110;
    curModes = '0;
    repeat (3) @(negedge clk);
    #2 checkAll("R1 during reset", '0);
    modeLoad = 1'b0;
    rstN     = 1'b1;
    @(negedge clk);
    #2 checkAll("R1 after reset", '0);

    // Table walk: every code, every source pattern, pairs offset
    for (int m = 0; m < 16; m++) begin
      loadModes({N{m[3:0]}});
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < N; i++) begin
          int pat = (p + i) % 4;
          srcA[i] = pat[1];
          srcB[i] = pat[0];
        end
        #2 checkAll(reqOf(m[3:0]), curModes);
      end
    end

    // R9: mode bus changes without the strobe are ignored
    @(negedge clk);
    modeIn = {N{4'd1}};
    srcA   = 4'b0101;
    srcB   = 4'b0011;
    repeat (3) @(negedge clk);
    #2 checkAll("R9 no load", curModes);

    // R10: distinct codes per pair
    loadModes({4'd8, 4'd5, 4'd10, 4'd2});
    srcA = 4'b1010;
    srcB = 4'b1100;
    #2 checkAll("R10 mixed", curModes);
    srcA = 4'b0110;
    srcB = 4'b0011;
    #2 checkAll("R10 mixed", curModes);

    // R11: sources change mid-cycle, outputs follow without an edge
    @(posedge clk);
    #3 srcA = 4'b1001;
    srcB = 4'b0101;
    #2 checkAll("R11 comb", curModes);

    // Same cycle: mode load and source change together
    @(negedge clk);
    modeIn   = {N{4'd9}};
    modeLoad = 1'b1;
    srcA     = 4'b1111;
    srcB     = 4'b0000;
    #2 checkAll("R9 old mode before edge", curModes);
    @(posedge clk);
    #2 checkAll("R9 new mode after edge", {N{4'd9}});
    @(negedge clk);
    modeLoad = 1'b0;
    curModes = {N{4'd9}};
    srcB     = 4'b1010;
    #2 checkAll("R7 stuck after load", curModes);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule